// File: doc/BRIEF.md
# Quasi-Bidirectional Port Expander

This block is an I2C target that controls a port of quasi-bidirectional pins. The port is 16 pins wide by default, or 8 pins when the `WIDE` parameter is cleared. There is no command byte and no register pointer. Each data byte of a write transaction goes straight into the output latch. Each byte of a read transaction returns the pin levels captured when the read began.

Each pin is modelled as follows. A latch bit of 0 drives the pin hard low. A latch bit of 1 leaves the pin on a weak pull-up, so outside logic (the `pin_pull_i` inputs) can pull it low and the pin can serve as an input. An active-low interrupt output flags any difference between the synchronized pin levels and the snapshot taken by the last read. The interrupt clears when another read takes a new snapshot, or when the pins return to the snapshot values.

The 7-bit address is the base address with its low three bits replaced by `addr_sel_i`. The base is 0x20, or 0x38 when `ALT_BASE` is set. SCL, SDA and the pin levels each pass through a two-flop synchronizer. START and STOP are recognised as SDA edges while SCL is high.

Top module: `qbd_expander`

## Requirements
- R1: Out of reset the latch is all ones, every `pin_o` bit is 1, `int_no` is 1 and `sda_oe_o` is 0.
- R2: The target pulls SDA low in the acknowledge slot only when the address byte's upper seven bits equal `{base[6:3], addr_sel_i}`. After any other address it drives nothing, and the data bytes that follow leave the latch unchanged.
- R3: In 16-bit mode the first data byte of a write holds pins 7..0 and the second holds pins 15..8. The latch keeps its old value after the first byte and takes both bytes together when the second byte is acknowledged.
- R4: `pin_o[i]` is 0 where latch bit i is 0. Where latch bit i is 1, `pin_o[i]` equals the inverse of `pin_pull_i[i]`.
- R5: A read returns the pin levels captured at address acknowledge, not the latch, low byte first, each byte MSB first.
- R6: `int_no` goes low when any synchronized pin level differs from the last read snapshot. It returns high after a read captures the current levels, or when the pins go back to the snapshot.
- R7: After the controller NACKs a read byte, the target leaves SDA released until the next START.
- R8: A STOP or repeated START after only one data byte of a 16-bit write discards that byte. The latch is unchanged, and byte pairing restarts with the next address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, oversamples SCL |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | I2C clock line level |
| sda_i | input | 1 | I2C data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain) |
| addr_sel_i | input | 3 | Low three address bits |
| pin_pull_i | input | PORT_W | 1 where outside logic pulls the pin low |
| pin_o | output | PORT_W | Resolved pin levels |
| int_no | output | 1 | Active-low change interrupt (open-drain) |

## Verification
The latch, and with it `pin_o`, updates 3 clock edges after the SCL falling edge that closes the last bit of a byte: two synchronizer flops, then the edge detector registering the commit. The acknowledge and each transmitted bit reach `sda_oe_o` in the same 3 edges. A pin change reaches `int_no` at the third edge, after two synchronizer flops and the interrupt register. The bench holds every SCL phase for 8 clocks and samples on falling clock edges at the end of each phase. For interrupt checks it waits 6 clocks, so every result has settled before it is compared.

// File: rtl/qbd_pkg.sv
package qbd_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_AACK, S_WDATA, S_WACK, S_RDATA, S_RACK
  } tgt_state_e;
endpackage

// File: rtl/qbd_sync.sv
module qbd_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '1;
      s2_q <= '1;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end
  assign q_o = s2_q;
endmodule

// File: rtl/qbd_i2c_target.sv
module qbd_i2c_target
  import qbd_pkg::*;
#(
  parameter int NBYTES = 2,
  parameter int IDX_W  = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_s_i,
  input  logic             sda_s_i,
  input  logic [6:0]       dev_addr_i,
  input  logic [7:0]       rd_byte_i,
  output logic             sda_oe_o,
  output logic             wr_stb_o,
  output logic [7:0]       wr_byte_o,
  output logic             rd_start_o,
  output logic [IDX_W-1:0] idx_o
);
  tgt_state_e       state_q;
  logic [3:0]       cnt_q;
  logic [7:0]       sh_q, tx_q;
  logic             rw_q, nack_q, scl_q, sda_q;
  logic [IDX_W-1:0] idx_q, idx_nxt;
  logic             scl_rise, scl_fall, start_c, stop_c, byte_end, addr_hit;

  assign scl_rise = scl_s_i & ~scl_q;
  assign scl_fall = ~scl_s_i & scl_q;
  assign start_c  = scl_s_i & scl_q & sda_q & ~sda_s_i;
  assign stop_c   = scl_s_i & scl_q & ~sda_q & sda_s_i;
  assign byte_end = scl_fall & (cnt_q == 4'd8) & ~start_c & ~stop_c;
  assign addr_hit = (sh_q[7:1] == dev_addr_i);
  assign idx_nxt  = (idx_q == IDX_W'(NBYTES-1)) ? '0 : idx_q + 1'b1;

  assign wr_stb_o   = byte_end & (state_q == S_WDATA);
  assign wr_byte_o  = sh_q;
  assign rd_start_o = byte_end & (state_q == S_ADDR) & addr_hit & sh_q[0];
  assign idx_o      = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cnt_q <= '0; sh_q <= '0; tx_q <= '0;
      rw_q <= 1'b0; nack_q <= 1'b0; idx_q <= '0;
      sda_oe_o <= 1'b0; scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s_i;
      sda_q <= sda_s_i;
      if (start_c) begin
        state_q <= S_ADDR; cnt_q <= '0; idx_q <= '0; sda_oe_o <= 1'b0;
      end else if (stop_c) begin
        state_q <= S_IDLE; sda_oe_o <= 1'b0;
      end else begin
        if (scl_rise) begin
          cnt_q <= cnt_q + 4'd1;
          sh_q  <= {sh_q[6:0], sda_s_i};
          if (state_q == S_RACK) nack_q <= sda_s_i;
        end
        if (scl_fall) begin
          unique case (state_q)
            S_ADDR: if (cnt_q == 4'd8) begin
              if (addr_hit) begin
                state_q <= S_AACK; sda_oe_o <= 1'b1; rw_q <= sh_q[0]; cnt_q <= '0;
              end else state_q <= S_IDLE;
            end
            S_AACK: if (cnt_q == 4'd1) begin
              cnt_q <= '0;
              if (rw_q) begin
                state_q <= S_RDATA; tx_q <= rd_byte_i; sda_oe_o <= ~rd_byte_i[7];
              end else begin
                state_q <= S_WDATA; sda_oe_o <= 1'b0;
              end
            end
            S_WDATA: if (cnt_q == 4'd8) begin
              state_q <= S_WACK; sda_oe_o <= 1'b1; cnt_q <= '0; idx_q <= idx_nxt;
            end
            S_WACK: if (cnt_q == 4'd1) begin
              state_q <= S_WDATA; sda_oe_o <= 1'b0; cnt_q <= '0;
            end
            S_RDATA: if (cnt_q == 4'd8) begin
              state_q <= S_RACK; sda_oe_o <= 1'b0; cnt_q <= '0; idx_q <= idx_nxt;
            end else if (cnt_q != 4'd0) begin
              tx_q <= {tx_q[6:0], 1'b0}; sda_oe_o <= ~tx_q[6];
            end
            S_RACK: if (cnt_q == 4'd1) begin
              cnt_q <= '0;
              if (nack_q) state_q <= S_IDLE;
              else begin
                state_q <= S_RDATA; tx_q <= rd_byte_i; sda_oe_o <= ~rd_byte_i[7];
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  // SDA only moves while SCL is low
  p_sda_scl_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !$past(scl_s_i));
  p_idle_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_IDLE) |-> !sda_oe_o);
  p_nack_ends_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_RACK && scl_fall && cnt_q == 4'd1 && nack_q && !start_c && !stop_c)
    |=> (state_q == S_IDLE));
endmodule

// File: rtl/qbd_port.sv
module qbd_port #(
  parameter int PORT_W = 16,
  parameter int NBYTES = 2,
  parameter int IDX_W  = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PORT_W-1:0] pin_s_i,
  input  logic              wr_stb_i,
  input  logic [7:0]        wr_byte_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              rd_start_i,
  output logic [PORT_W-1:0] latch_o,
  output logic [7:0]        rd_byte_o,
  output logic              int_o
);
  logic [PORT_W-1:0] latch_q, snap_q, commit_val;
  logic [7:0]        stage_q;
  logic              int_q, last_byte;

  assign last_byte = (idx_i == IDX_W'(NBYTES-1));

  generate
    if (NBYTES == 1) begin : g_narrow
      assign commit_val = wr_byte_i;
    end else begin : g_wide
      assign commit_val = {wr_byte_i, stage_q};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= '1; snap_q <= '1; stage_q <= '0; int_q <= 1'b0;
    end else begin
      if (wr_stb_i) begin
        if (last_byte) latch_q <= commit_val;
        else           stage_q <= wr_byte_i;
      end
      if (rd_start_i) snap_q <= pin_s_i;
      int_q <= (pin_s_i != snap_q);
    end
  end

  assign latch_o   = latch_q;
  assign rd_byte_o = snap_q[8*int'(idx_i) +: 8];
  assign int_o     = int_q;

  p_latch_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_stb_i && last_byte) |=> $stable(latch_q));
  p_int_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_start_i ##1 $stable(pin_s_i)) |=> !int_q);
endmodule

// File: rtl/qbd_expander.sv
module qbd_expander #(
  parameter bit WIDE     = 1'b1,
  parameter bit ALT_BASE = 1'b0,
  localparam int PORT_W  = WIDE ? 16 : 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [2:0]        addr_sel_i,
  input  logic [PORT_W-1:0] pin_pull_i,
  output logic [PORT_W-1:0] pin_o,
  output logic              int_no
);
  localparam int         NBYTES = PORT_W / 8;
  localparam int         IDX_W  = 1;
  localparam logic [6:0] BASE   = ALT_BASE ? 7'h38 : 7'h20;

  logic [1:0]        bus_s;
  logic [PORT_W-1:0] pin_s, latch;
  logic [7:0]        wr_byte, rd_byte;
  logic [IDX_W-1:0]  idx;
  logic              wr_stb, rd_start, int_q;

  qbd_sync #(.W(2)) u_bus_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i({scl_i, sda_i}), .q_o(bus_s));

  qbd_sync #(.W(PORT_W)) u_pin_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pin_o), .q_o(pin_s));

  qbd_i2c_target #(.NBYTES(NBYTES), .IDX_W(IDX_W)) u_target (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_s_i(bus_s[1]), .sda_s_i(bus_s[0]),
    .dev_addr_i({BASE[6:3], addr_sel_i}), .rd_byte_i(rd_byte),
    .sda_oe_o(sda_oe_o), .wr_stb_o(wr_stb), .wr_byte_o(wr_byte),
    .rd_start_o(rd_start), .idx_o(idx));

  qbd_port #(.PORT_W(PORT_W), .NBYTES(NBYTES), .IDX_W(IDX_W)) u_port (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_s_i(pin_s), .wr_stb_i(wr_stb),
    .wr_byte_i(wr_byte), .idx_i(idx), .rd_start_i(rd_start),
    .latch_o(latch), .rd_byte_o(rd_byte), .int_o(int_q));

  // strong low on latch 0, weak high otherwise
  assign pin_o  = latch & ~pin_pull_i;
  assign int_no = ~int_q;
endmodule

// File: tb/qbd_expander_bench.sv
`timescale 1ns/1ps
module qbd_expander_bench;
  localparam int H = 8;
  localparam logic [6:0] ADDR = 7'h25;

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_low = 1'b0;
  logic [15:0] pull = '0;
  logic [15:0] pin;
  logic sda_oe, int_n, watch = 1'b0, drv_seen = 1'b0, done = 1'b0;
  int n_chk = 0, n_fail = 0;
  wire sda_bus = ~(m_low | sda_oe);

  always #2 clk = ~clk;

  qbd_expander u_qbd_expander (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .addr_sel_i(3'b101), .pin_pull_i(pull),
    .pin_o(pin), .int_no(int_n));

  always @(posedge clk) if (watch && sda_oe) drv_seen <= 1'b1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic hp(); repeat (H) @(negedge clk); endtask
  task automatic w(input int n); repeat (n) @(negedge clk); endtask

  task automatic i2c_start(); m_low = 0; m_scl = 1; hp(); m_low = 1; hp(); m_scl = 0; hp(); endtask
  task automatic i2c_rstart(); m_low = 0; hp(); m_scl = 1; hp(); m_low = 1; hp(); m_scl = 0; hp(); endtask
  task automatic i2c_stop(); m_low = 1; hp(); m_scl = 1; hp(); m_low = 0; hp(); endtask

  task automatic send(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_low = ~b[i]; hp(); m_scl = 1; hp(); m_scl = 0;
    end
    m_low = 0; hp(); m_scl = 1; hp(); ack = ~sda_bus; m_scl = 0;
  endtask

  task automatic recv(output logic [7:0] b, input logic nack);
    m_low = 0;
    for (int i = 7; i >= 0; i--) begin
      hp(); m_scl = 1; hp(); b[i] = sda_bus; m_scl = 0;
    end
    m_low = ~nack; hp(); m_scl = 1; hp(); m_scl = 0; m_low = 0;
  endtask

  task automatic rd16(output logic [15:0] v, output logic ack);
    logic [7:0] lo, hi;
    i2c_start(); send({ADDR, 1'b1}, ack); recv(lo, 1'b0); recv(hi, 1'b1); i2c_stop();
    v = {hi, lo};
  endtask

  task automatic t_reset();
    chk(pin == 16'hFFFF, "R1 pins", pin, 16'hFFFF);
    chk(int_n == 1'b1, "R1 int", int_n, 1);
    chk(sda_oe == 1'b0, "R1 sda", sda_oe, 0);
  endtask

  task automatic t_write();
    logic ack;
    i2c_start(); send({ADDR, 1'b0}, ack);
    chk(ack, "R2 ack own address", ack, 1);
    send(8'h34, ack); w(H);
    chk(pin == 16'hFFFF, "R3 latch held after first byte", pin, 16'hFFFF);
    send(8'h12, ack); hp();
    chk(pin == 16'h1234, "R3 both bytes applied", pin, 16'h1234);
    i2c_stop(); w(6);
    chk(int_n == 1'b0, "R6 int on driven change", int_n, 0);
  endtask

  task automatic t_read();
    logic [15:0] v; logic ack;
    pull = 16'h0010; w(4);
    chk(pin == 16'h1224, "R4 weak pin pulled low", pin, 16'h1224);
    pull = 16'h0110; w(4);
    chk(pin == 16'h1224, "R4 driven-low pin stays low", pin, 16'h1224);
    rd16(v, ack); w(6);
    chk(v == 16'h1224, "R5 read returns pin levels", v, 16'h1224);
    chk(int_n == 1'b1, "R6 int cleared by read", int_n, 1);
  endtask

  task automatic t_int();
    pull = 16'h0130; w(6);
    chk(int_n == 1'b0, "R6 int on input change", int_n, 0);
    pull = 16'h0110; w(6);
    chk(int_n == 1'b1, "R6 int released on return", int_n, 1);
  endtask

  task automatic t_addr();
    logic ack;
    i2c_start(); send({7'h26, 1'b0}, ack);
    chk(!ack, "R2 no ack foreign address", ack, 0);
    send(8'h00, ack); send(8'h00, ack); i2c_stop(); w(4);
    chk(pin == 16'h1224, "R2 foreign write ignored", pin, 16'h1224);
  endtask

  task automatic t_nack();
    logic ack; logic [7:0] lo;
    pull = 16'h0000; w(6);
    i2c_start(); send({ADDR, 1'b1}, ack); recv(lo, 1'b1);
    chk(lo == 8'h34, "R5 low byte first", lo, 8'h34);
    watch = 1;
    for (int i = 0; i < 9; i++) begin hp(); m_scl = 1; hp(); m_scl = 0; end
    hp(); watch = 0;
    chk(!drv_seen, "R7 SDA released after NACK", drv_seen, 0);
    i2c_stop();
  endtask

  task automatic t_abort();
    logic ack;
    i2c_start(); send({ADDR, 1'b0}, ack); send(8'h00, ack); i2c_stop(); w(4);
    chk(pin == 16'h1234, "R8 STOP drops lone byte", pin, 16'h1234);
    i2c_start(); send({ADDR, 1'b0}, ack); send(8'h00, ack);
    i2c_rstart(); send({ADDR, 1'b0}, ack); send(8'hF0, ack); send(8'h0F, ack); i2c_stop(); w(4);
    chk(pin == 16'h0FF0, "R8 repeated START restarts pairing", pin, 16'h0FF0);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    w(10); rst_n = 1; w(4);
    t_reset(); t_write(); t_read(); t_int(); t_addr(); t_nack(); t_abort();
    done = 1;
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=%h exp=%h", 0, 1);
      summary();
    end
  end
endmodule